// File: doc/BRIEF.md
# Single-Wire Memory Bus Slave Protocol Engine

This block is the byte-level controller on the slave side of a single-wire serial memory bus where every bit period carries one decoded bit. A bit receiver in front of it hands over one strobe per bit period. Each strobe carries the decoded bit value. The engine groups those strobes into ten-period frames: eight byte bits sent most significant first, one master acknowledge bit, and one slave acknowledge slot. During the slot the engine raises `sak_o` to tell the bit transmitter to send a positive acknowledge. Leaving `sak_o` low means the slot passes with no mid-bit edge, which the master reads as a negative acknowledge.

Each transaction opens with a start header. The device address byte comes next, then a command byte, then any payload bytes. After each byte the engine decides whether to acknowledge. A master acknowledge of 1 continues the operation and 0 ends it. When a write-type command ends properly, the engine sends the memory back end a one-clock write-cycle trigger. A write-busy input from the back end blocks commands that must not start while a write cycle is running. A standby pulse restarts the engine. A loss of bit synchronisation parks the engine until that standby pulse arrives.

Top module: `swp_slave_engine`

## Requirements
- R1: After reset or a standby pulse (`standby_i`, which takes priority over every other input), `sak_o` and `wr_start_o` are 0 and the engine waits for a start header with the frame position at bit 0.
- R2: A frame is ten `rx_valid_i` strobes: eight byte bits most significant first, the master acknowledge bit, then the slave slot. When the engine acknowledges, `sak_o` rises on the clock that registers the master acknowledge strobe and falls on the clock that registers the slot strobe.
- R3: The engine never acknowledges the start header. The header must be 0x55 and carry a master acknowledge of 1; otherwise the engine ignores everything until a standby pulse.
- R4: The address byte is acknowledged only when it equals {1010, device code}, with a device code of 0000 when parameter DEV_SEL is 0 and 0001 when DEV_SEL is 1 (default 0, so 0xA0 matches).
- R5: A non-matching address byte is not acknowledged, and every later frame is ignored with no acknowledge until a standby pulse.
- R6: The recognised commands are READ 0x03, CRRD 0x06, WRITE 0x6C, WRSR 0x6E, SETAL 0x67, ERAL 0x6D, WREN 0x96, WRDI 0x91 and RDSR 0x05. Any other command byte is not acknowledged, and the engine then ignores frames until a standby pulse.
- R7: While `wr_busy_i` is 1 at the command's acknowledge bit, READ, CRRD, WRITE, WRSR, SETAL and ERAL are not acknowledged. WREN, WRDI and RDSR are still acknowledged.
- R8: A master acknowledge of 0 right after a matching address byte is still acknowledged, and the engine then returns to waiting for a start header.
- R9: A master acknowledge of 0 before a command reaches its minimum number of bytes after the command byte is not acknowledged. The minimums are READ 3, WRITE 3, CRRD 1, RDSR 1, WRSR 1, and 0 for the rest. After such a stop the engine ignores frames until a standby pulse.
- R10: `wr_start_o` is a one-clock pulse on the clock after the slot strobe of an acknowledged terminating frame of WRITE, WRSR, ERAL or SETAL. WRITE therefore needs at least one data byte after its two address bytes, and WRSR needs one data byte. A cut-short command gives no pulse.
- R11: A `sync_err_i` pulse drops `sak_o` at once. The engine then gives no acknowledge and no write trigger until a standby pulse.
- R12: A master acknowledge of 1 after a valid command or payload byte is acknowledged, and the engine expects another payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby pulse: restart and wait for a header |
| sync_err_i | input | 1 | Bit receiver lost synchronisation |
| rx_valid_i | input | 1 | One strobe per completed bit period |
| rx_bit_i | input | 1 | Decoded bit value with the strobe |
| wr_busy_i | input | 1 | Back end is running a write cycle |
| sak_o | output | 1 | Drive a positive acknowledge in the slave slot |
| wr_start_o | output | 1 | One-clock write-cycle trigger |

## Verification
The bench targets the silence rules. Header frames must never be acknowledged, and an engine that acknowledged them would fight other slaves on the bus. After a mismatched address, an unknown or busy-blocked command, a bad header or a sync loss, every later frame must stay silent until a standby pulse; an engine that fell back into decoding would answer traffic meant for another device. Termination is covered from several angles. A stop right after the address must still be acknowledged. WRITE is stopped after only its address bytes, and WRSR is stopped with no data byte. ERAL, which needs no payload, must trigger on its own command frame. A wrong byte counter would start a write cycle with no data, or would miss the trigger.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam int BYTE_W     = 8;
    localparam int FRAME_LEN  = BYTE_W + 2;
    localparam int PH_W       = $clog2(FRAME_LEN);
    localparam int MAK_IDX    = BYTE_W;
    localparam int SLOT_IDX   = BYTE_W + 1;

    localparam logic [BYTE_W-1:0] HDR_BYTE = 8'h55;
    localparam logic [3:0]        FAMILY   = 4'b1010;

    localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_CRRD  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h6C;
    localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h6E;
    localparam logic [BYTE_W-1:0] OP_SETAL = 8'h67;
    localparam logic [BYTE_W-1:0] OP_ERAL  = 8'h6D;
    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h96;
    localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h91;
    localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_IGN
    } eng_state_e;
endpackage

// File: rtl/swp_framer.sv
module swp_framer
    import swp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              rx_valid_i,
    input  logic              rx_bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [PH_W-1:0]   phase_o,
    output logic              mak_stb_o,
    output logic              slot_stb_o
);
    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [BYTE_W-1:0] shreg;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d = frm_q;
        if (restart_i) begin
            frm_d.phase = '0;
        end else if (rx_valid_i) begin
            if (frm_q.phase < PH_W'(MAK_IDX)) begin
                frm_d.shreg = {frm_q.shreg[BYTE_W-2:0], rx_bit_i};
            end
            if (frm_q.phase == PH_W'(SLOT_IDX)) begin
                frm_d.phase = '0;
            end else begin
                frm_d.phase = frm_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign byte_o     = frm_q.shreg;
    assign phase_o    = frm_q.phase;
    assign mak_stb_o  = rx_valid_i && !restart_i && (frm_q.phase == PH_W'(MAK_IDX));
    assign slot_stb_o = rx_valid_i && !restart_i && (frm_q.phase == PH_W'(SLOT_IDX));
endmodule

// File: rtl/swp_cmd_decode.sv
module swp_cmd_decode
    import swp_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [BYTE_W-1:0] op_i,
    input  logic              busy_i,
    output logic              valid_o,
    output logic              wr_cmd_o,
    output logic [CNT_W-1:0]  min_len_o
);
    logic known;
    logic blocked_when_busy;

    always_comb begin
        known             = 1'b1;
        blocked_when_busy = 1'b1;
        wr_cmd_o          = 1'b0;
        min_len_o         = '0;
        unique case (op_i)
            OP_READ:  min_len_o = CNT_W'(3);
            OP_CRRD:  min_len_o = CNT_W'(1);
            OP_WRITE: begin
                min_len_o = CNT_W'(3);
                wr_cmd_o  = 1'b1;
            end
            OP_WRSR: begin
                min_len_o = CNT_W'(1);
                wr_cmd_o  = 1'b1;
            end
            OP_SETAL, OP_ERAL: wr_cmd_o = 1'b1;
            OP_WREN, OP_WRDI:  blocked_when_busy = 1'b0;
            OP_RDSR: begin
                min_len_o         = CNT_W'(1);
                blocked_when_busy = 1'b0;
            end
            default: known = 1'b0;
        endcase
        valid_o = known && !(busy_i && blocked_when_busy);
    end
endmodule

// File: rtl/swp_slave_engine.sv
module swp_slave_engine
    import swp_pkg::*;
#(
    parameter bit DEV_SEL = 1'b0,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic sync_err_i,
    input  logic rx_valid_i,
    input  logic rx_bit_i,
    input  logic wr_busy_i,
    output logic sak_o,
    output logic wr_start_o
);
    localparam logic [BYTE_W-1:0] MY_ADDR  = {FAMILY, 3'b000, DEV_SEL};
    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

    typedef struct packed {
        eng_state_e        state;
        eng_state_e        nxt;
        logic [BYTE_W-1:0] cmd;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              sak;
        logic              pend;
        logic              wr;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [BYTE_W-1:0] rx_byte;
    logic [PH_W-1:0]   frm_phase;
    logic              mak_stb;
    logic              slot_stb;
    logic [BYTE_W-1:0] dec_op;
    logic              dec_valid;
    logic              dec_wr;
    logic [CNT_W-1:0]  dec_min;
    logic [CNT_W-1:0]  cnt_inc;

    swp_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (standby_i),
        .rx_valid_i (rx_valid_i),
        .rx_bit_i   (rx_bit_i),
        .byte_o     (rx_byte),
        .phase_o    (frm_phase),
        .mak_stb_o  (mak_stb),
        .slot_stb_o (slot_stb)
    );

    assign dec_op  = (eng_q.state == ST_CMD) ? rx_byte : eng_q.cmd;
    assign cnt_inc = (eng_q.cnt == CNT_MAX) ? eng_q.cnt : eng_q.cnt + 1'b1;

    swp_cmd_decode #(.CNT_W(CNT_W)) u_dec (
        .op_i      (dec_op),
        .busy_i    (eng_q.busy),
        .valid_o   (dec_valid),
        .wr_cmd_o  (dec_wr),
        .min_len_o (dec_min)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.wr   = 1'b0;
        eng_d.busy = wr_busy_i;
        if (standby_i) begin
            eng_d.state = ST_HDR;
            eng_d.nxt   = ST_HDR;
            eng_d.sak   = 1'b0;
            eng_d.pend  = 1'b0;
            eng_d.cnt   = '0;
        end else if (sync_err_i) begin
            eng_d.state = ST_IGN;
            eng_d.nxt   = ST_IGN;
            eng_d.sak   = 1'b0;
            eng_d.pend  = 1'b0;
        end else if (slot_stb) begin
            eng_d.sak   = 1'b0;
            eng_d.wr    = eng_q.pend;
            eng_d.pend  = 1'b0;
            eng_d.state = eng_q.nxt;
        end else if (mak_stb) begin
            eng_d.sak  = 1'b0;
            eng_d.pend = 1'b0;
            eng_d.nxt  = ST_IGN;
            unique case (eng_q.state)
                ST_HDR: begin
                    if (rx_byte == HDR_BYTE && rx_bit_i) begin
                        eng_d.nxt = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (rx_byte == MY_ADDR) begin
                        eng_d.sak = 1'b1;
                        eng_d.nxt = rx_bit_i ? ST_CMD : ST_HDR;
                    end
                end
                ST_CMD: begin
                    if (dec_valid) begin
                        eng_d.cmd = rx_byte;
                        eng_d.cnt = '0;
                        if (rx_bit_i) begin
                            eng_d.sak = 1'b1;
                            eng_d.nxt = ST_DATA;
                        end else if (dec_min == '0) begin
                            eng_d.sak  = 1'b1;
                            eng_d.pend = dec_wr;
                            eng_d.nxt  = ST_HDR;
                        end
                    end
                end
                ST_DATA: begin
                    eng_d.cnt = cnt_inc;
                    if (rx_bit_i) begin
                        eng_d.sak = 1'b1;
                        eng_d.nxt = ST_DATA;
                    end else if (cnt_inc >= dec_min) begin
                        eng_d.sak  = 1'b1;
                        eng_d.pend = dec_wr;
                        eng_d.nxt  = ST_HDR;
                    end
                end
                default: eng_d.nxt = ST_IGN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.state <= ST_HDR;
            eng_q.nxt   <= ST_HDR;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sak_o      = eng_q.sak;
    assign wr_start_o = eng_q.wr;
endmodule

// File: rtl/swp_slave_engine_chk.sv
module swp_slave_engine_chk
    import swp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            standby_i,
    input logic            sync_err_i,
    input logic            rx_valid_i,
    input logic            sak_o,
    input logic            wr_start_o,
    input logic [PH_W-1:0] phase,
    input eng_state_e      state
);
    // R2: an acknowledge is only driven while the frame sits in its slave slot
    p_sak_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sak_o |-> (phase == PH_W'(SLOT_IDX)));

    // R3: waiting on or checking a header never drives an acknowledge
    p_hdr_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR) |-> !sak_o);

    // R11: the parked state drives nothing
    p_ign_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGN) |-> (!sak_o && !wr_start_o));

    // R11: a sync loss without standby silences the next cycle
    p_sync_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err_i && !standby_i) |=> (!sak_o && !wr_start_o));

    // R10: the trigger lasts a single clock
    p_wr_one_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |=> !wr_start_o);

    // R10: the trigger follows a slot strobe
    p_wr_after_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |-> ($past(rx_valid_i) && $past(phase) == PH_W'(SLOT_IDX)));

    // R1: standby returns to header wait with nothing driven
    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!sak_o && !wr_start_o && state == ST_HDR && phase == '0));
endmodule

bind swp_slave_engine swp_slave_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby_i  (standby_i),
    .sync_err_i (sync_err_i),
    .rx_valid_i (rx_valid_i),
    .sak_o      (sak_o),
    .wr_start_o (wr_start_o),
    .phase      (frm_phase),
    .state      (eng_q.state)
);

// File: tb/tb_swp_slave_engine.sv
`timescale 1ns/1ps
module tb_swp_slave_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_i = 1'b0;
    logic sync_err_i = 1'b0;
    logic rx_valid_i = 1'b0;
    logic rx_bit_i = 1'b0;
    logic wr_busy_i = 1'b0;
    logic sak_o;
    logic wr_start_o;

    always #4 clk = ~clk;

    swp_slave_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .sync_err_i (sync_err_i),
        .rx_valid_i (rx_valid_i),
        .rx_bit_i   (rx_bit_i),
        .wr_busy_i  (wr_busy_i),
        .sak_o      (sak_o),
        .wr_start_o (wr_start_o)
    );

    typedef struct {
        logic  sak;
        logic  wr;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   n_checks = 0;
    int   n_fails  = 0;
    logic sak_probe = 1'b0;
    logic wr_probe  = 1'b0;
    bit   done      = 1'b0;

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sak_probe) begin
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL R2 scoreboard: got empty queue expected an item");
                end else begin
                    cur = exp_q.pop_front();
                    check(sak_o, cur.sak, {cur.tag, " sak"});
                end
            end
            if (wr_probe) begin
                check(wr_start_o, cur.wr, {cur.tag, " wr_start"});
            end
        end
    end

    task automatic send_bit(input logic v);
        @(posedge clk);
        #1;
        rx_valid_i = 1'b1;
        rx_bit_i   = v;
        @(posedge clk);
        #1;
        rx_valid_i = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic mak,
                              input logic exp_sak, input logic exp_wr, input string tag);
        exp_t item;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(mak);
        item.sak = exp_sak;
        item.wr  = exp_wr;
        item.tag = tag;
        exp_q.push_back(item);
        sak_probe = 1'b1;
        @(posedge clk);
        #1;
        sak_probe = 1'b0;
        send_bit(1'b0);
        wr_probe = 1'b1;
        @(posedge clk);
        #1;
        wr_probe = 1'b0;
    endtask

    task automatic pulse_standby();
        @(posedge clk);
        #1;
        standby_i = 1'b1;
        @(posedge clk);
        #1;
        standby_i = 1'b0;
        check(sak_o, 1'b0, "R1 sak after standby");
    endtask

    task automatic pulse_sync();
        @(posedge clk);
        #1;
        sync_err_i = 1'b1;
        @(posedge clk);
        #1;
        sync_err_i = 1'b0;
    endtask

    task automatic open_txn(input string tag);
        send_frame(8'h55, 1'b1, 1'b0, 1'b0, {"R3 header ", tag});
        send_frame(8'hA0, 1'b1, 1'b1, 1'b0, {"R4 address ", tag});
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(sak_o, 1'b0, "R1 reset sak");
        check(wr_start_o, 1'b0, "R1 reset wr_start");

        // full WRITE with two data bytes
        open_txn("write");
        send_frame(8'h6C, 1'b1, 1'b1, 1'b0, "R6 WRITE cmd");
        send_frame(8'h00, 1'b1, 1'b1, 1'b0, "R12 addr hi");
        send_frame(8'h10, 1'b1, 1'b1, 1'b0, "R12 addr lo");
        send_frame(8'h5A, 1'b1, 1'b1, 1'b0, "R12 data0");
        send_frame(8'hC3, 1'b0, 1'b1, 1'b1, "R10 WRITE end");

        // stop right after address, no standby between
        send_frame(8'h55, 1'b1, 1'b0, 1'b0, "R3 header again");
        send_frame(8'hA0, 1'b0, 1'b1, 1'b0, "R8 stop after address");

        // address mismatch, then ignored traffic
        send_frame(8'h55, 1'b1, 1'b0, 1'b0, "R3 header mis");
        send_frame(8'hA1, 1'b1, 1'b0, 1'b0, "R5 mismatch");
        send_frame(8'h96, 1'b0, 1'b0, 1'b0, "R5 ignored cmd");
        pulse_standby();

        // unknown command
        open_txn("unk");
        send_frame(8'hFF, 1'b1, 1'b0, 1'b0, "R6 unknown cmd");
        send_frame(8'h55, 1'b1, 1'b0, 1'b0, "R6 ignored after unknown");
        pulse_standby();

        // busy rules
        wr_busy_i = 1'b1;
        open_txn("busy");
        send_frame(8'h03, 1'b1, 1'b0, 1'b0, "R7 READ while busy");
        pulse_standby();
        open_txn("busy2");
        send_frame(8'h96, 1'b0, 1'b1, 1'b0, "R7 WREN while busy");
        wr_busy_i = 1'b0;

        // WRITE stopped after its address bytes
        open_txn("short");
        send_frame(8'h6C, 1'b1, 1'b1, 1'b0, "R6 WRITE cmd short");
        send_frame(8'h01, 1'b1, 1'b1, 1'b0, "R12 short addr hi");
        send_frame(8'h02, 1'b0, 1'b0, 1'b0, "R9 WRITE cut after addr");
        pulse_standby();

        // WRSR with one data byte
        open_txn("wrsr");
        send_frame(8'h6E, 1'b1, 1'b1, 1'b0, "R6 WRSR cmd");
        send_frame(8'h0C, 1'b0, 1'b1, 1'b1, "R10 WRSR end");

        // WRSR stopped on its command byte
        open_txn("wrsr0");
        send_frame(8'h6E, 1'b0, 1'b0, 1'b0, "R9 WRSR no data");
        pulse_standby();

        // ERAL needs no payload
        open_txn("eral");
        send_frame(8'h6D, 1'b0, 1'b1, 1'b1, "R10 ERAL end");

        // sync loss parks the engine
        open_txn("sync");
        pulse_sync();
        check(sak_o, 1'b0, "R11 sak after sync loss");
        send_frame(8'h96, 1'b1, 1'b0, 1'b0, "R11 parked cmd");
        send_frame(8'hA0, 1'b1, 1'b0, 1'b0, "R11 parked addr");
        pulse_standby();
        open_txn("resume");
        send_frame(8'h05, 1'b1, 1'b1, 1'b0, "R1 RDSR after standby");
        pulse_standby();

        // bad header
        send_frame(8'h54, 1'b1, 1'b0, 1'b0, "R3 bad header");
        send_frame(8'hA0, 1'b1, 1'b0, 1'b0, "R3 ignored after bad header");
        pulse_standby();

        // header with master stop
        send_frame(8'h55, 1'b0, 1'b0, 1'b0, "R3 header with stop");
        send_frame(8'hA0, 1'b1, 1'b0, 1'b0, "R3 ignored after header stop");
        pulse_standby();

        repeat (4) @(posedge clk);
        #1;
        check(wr_start_o, 1'b0, "R10 idle no trigger");
        done = 1'b1;
        finish_run();
    end
endmodule